// File: doc/BRIEF.md
# Centre-Aligned PWM Generator

This block produces one pulse-width-modulated output from a counter that runs as a triangle. The counter climbs from zero to a peak, falls back to zero, and repeats. One compare value sets the duty cycle. The output takes a rising or falling edge where the counter meets the compare value, and the edge direction depends on the slope. Each high pulse is therefore centred on the valley of the triangle.

The peak follows from a selectable resolution of 8, 9 or 10 bits. No register sets the period. The period is changed only through the resolution and a clock prescaler.

Software writes two words through a simple write port. One word holds the compare value. The other holds the resolution, the prescaler code and an output-invert bit. A compare write goes to a holding register first. The counter takes the new value only when it turns at the peak, so a duty change never cuts a pulse short.

Top module: `sympwm_top`

## Requirements
- R1: After reset the output is low, the compare value is 0 and the configuration word is 0: 8-bit resolution, prescaler stopped, not inverted. An asserted reset forces the output low at once.
- R2: The resolution field is config bits [1:0]. Codes 00 and 01 give a peak of 255, code 10 gives 511 and code 11 gives 1023.
- R3: On each prescaled tick the counter moves one step. It goes 0, 1, …, peak, peak−1, …, 1, 0, 1, … and repeats, so one period lasts 2×peak ticks.
- R4: When not inverted and 0 < C < peak, the output is high while the rising count is below C and while the falling count is at or below C. It falls when the rising count reaches C and rises when the falling count reaches C. Each period holds exactly 2×C high ticks.
- R5: A compare value of 0 holds the output constantly low. A compare value at or above the peak holds it constantly high. Neither case produces a pulse.
- R6: The invert bit (config bit 5) complements the output level.
- R7: A compare write (address 0, data bits [9:0]) lands in a holding register. It becomes active only on the tick that turns the counter down from the peak.
- R8: The prescaler field is config bits [4:2]. Code 1 gives divide by 1, code 2 divide by 8, code 3 by 64, code 4 by 256 and code 5 by 1024. Codes 0, 6 and 7 stop the counter.
- R9: While the prescaler is stopped, the counter and the output hold their values.
- R10: A configuration write (address 1, data bits [5:0]) takes effect on the next clock. If the rising count is at or above a newly smaller peak, the counter turns down from the new peak minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Selects the word: 0 for compare, 1 for configuration |
| wr_data | input | 10 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
Assertions check on every cycle that the counter steps by exactly one in the direction of its slope and stays still between ticks. They also check that the active compare value changes only on the turn at the peak, and that compare values of 0 and at or above the peak force a constant level. The bench scenarios cover the rest. They measure duty and period for each resolution and prescaler setting and confirm the inverted output. They show that a compare write made in the middle of a pulse leaves that pulse whole. They also show that shrinking the resolution while the count sits above the new peak turns the counter down at once.

// File: rtl/sympwm_pkg.sv
package sympwm_pkg;
  localparam int CNT_W = 10;
  localparam int PRE_W = 10;

  // prescaler selection codes; all other values stop the counter
  localparam logic [2:0] PS_DIV1    = 3'd1;
  localparam logic [2:0] PS_DIV8    = 3'd2;
  localparam logic [2:0] PS_DIV64   = 3'd3;
  localparam logic [2:0] PS_DIV256  = 3'd4;
  localparam logic [2:0] PS_DIV1024 = 3'd5;

  typedef struct packed {
    logic       invert;
    logic [2:0] presc;
    logic [1:0] res;
  } cfg_t;

  // resolutions span CNT_W-2 .. CNT_W bits; code 0 aliases code 1
  function automatic logic [CNT_W-1:0] peak_of(input logic [1:0] res);
    int bits;
    bits = CNT_W - 2 + ((res == 2'd0) ? 0 : int'(res) - 1);
    return CNT_W'((64'd1 << bits) - 64'd1);
  endfunction

  // terminal count of the prescaler (divide ratio minus one), -1 when stopped
  function automatic int presc_last(input logic [2:0] code);
    case (code)
      PS_DIV1:    return 0;
      PS_DIV8:    return 7;
      PS_DIV64:   return 63;
      PS_DIV256:  return 255;
      PS_DIV1024: return 1023;
      default:    return -1;
    endcase
  endfunction
endpackage

// File: rtl/sympwm_presc.sv
module sympwm_presc #(
  parameter int PRE_W = sympwm_pkg::PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  output logic       tick
);
  import sympwm_pkg::*;

  logic [PRE_W-1:0] div_q, div_d;
  logic             run;
  logic [PRE_W-1:0] last;

  always_comb begin
    run  = (presc_last(code) >= 0);
    last = run ? PRE_W'(presc_last(code)) : '0;
  end

  always_comb begin
    div_d = div_q;
    tick  = 1'b0;
    if (!run) begin
      div_d = '0;
    end else if (div_q >= last) begin
      div_d = '0;
      tick  = 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/sympwm_slope.sv
module sympwm_slope #(
  parameter int CNT_W = sympwm_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] peak,
  output logic [CNT_W-1:0] cnt,
  output logic             rising,
  output logic             turn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    turn  = 1'b0;
    if (tick) begin
      if (up_q) begin
        if (cnt_q >= peak) begin
          cnt_d = peak - ONE;
          up_d  = 1'b0;
          turn  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = ONE;
          up_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt    = cnt_q;
  assign rising = up_q;
endmodule

// File: rtl/sympwm_cmp.sv
module sympwm_cmp #(
  parameter int CNT_W = sympwm_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rising,
  input  logic [CNT_W-1:0] peak,
  input  logic             invert,
  output logic [CNT_W-1:0] cmp_active,
  output logic             pwm
);
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             pwm_q, pwm_d;
  logic             level;

  always_comb begin
    hold_d = wr_cmp ? wr_val : hold_q;
    act_d  = load ? hold_q : act_q;
  end

  always_comb begin
    if (act_q == '0)        level = 1'b0;
    else if (act_q >= peak) level = 1'b1;
    else if (rising)        level = (cnt < act_q);
    else                    level = (cnt <= act_q);
    pwm_d = level ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
      pwm_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
      pwm_q  <= pwm_d;
    end
  end

  assign cmp_active = act_q;
  assign pwm        = pwm_q;
endmodule

// File: rtl/sympwm_top.sv
module sympwm_top #(
  parameter int CNT_W = sympwm_pkg::CNT_W,
  parameter int PRE_W = sympwm_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out
);
  import sympwm_pkg::*;

  localparam int CFG_W = $bits(cfg_t);

  cfg_t             cfg_q, cfg_d;
  logic             wr_cfg, wr_cmp;
  logic             tick, turn, rising, invert;
  logic [CNT_W-1:0] cnt, peak, cmp_act;

  always_comb begin
    wr_cmp = wr_en && (wr_addr == 1'b0);
    wr_cfg = wr_en && (wr_addr == 1'b1);
    cfg_d  = wr_cfg ? cfg_t'(wr_data[CFG_W-1:0]) : cfg_q;
    peak   = peak_of(cfg_q.res);
    invert = cfg_q.invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  sympwm_presc #(.PRE_W(PRE_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .code (cfg_q.presc),
    .tick (tick)
  );

  sympwm_slope #(.CNT_W(CNT_W)) u_slope (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .peak  (peak),
    .cnt   (cnt),
    .rising(rising),
    .turn  (turn)
  );

  sympwm_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmp    (wr_cmp),
    .wr_val    (wr_data),
    .load      (turn),
    .cnt       (cnt),
    .rising    (rising),
    .peak      (peak),
    .invert    (invert),
    .cmp_active(cmp_act),
    .pwm       (pwm_out)
  );
endmodule

// File: rtl/sympwm_chk.sv
module sympwm_chk #(
  parameter int CNT_W = sympwm_pkg::CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             turn,
  input logic             rising,
  input logic             invert,
  input logic             pwm_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] peak,
  input logic [CNT_W-1:0] cmp_act
);
  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rising && cnt < peak) |=> (cnt == $past(cnt) + 1'b1));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rising && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R9
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt) && $stable(rising)));

  // R7
  cmp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !turn |=> $stable(cmp_act));

  // R5
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0 && !invert) |=> !pwm_out);

  // R5
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act != '0 && cmp_act >= peak && !invert) |=> pwm_out);
endmodule

bind sympwm_top sympwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .turn   (turn),
  .rising (rising),
  .invert (invert),
  .pwm_out(pwm_out),
  .cnt    (cnt),
  .peak   (peak),
  .cmp_act(cmp_act)
);

// File: tb/sympwm_top_tb.sv
`timescale 1ns/1ps
module sympwm_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       wr_addr;
  logic [9:0] wr_data;
  logic       pwm_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sympwm_top u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [1:0]  res;
    logic [2:0]  pre;
    logic [9:0]  cmp;
    logic        inv;
    int unsigned win;
    int unsigned high;
  } vec_t;

  // window = 2*peak*div; expected high count from R4/R5/R6
  localparam vec_t VEC [12] = '{
    '{2'd1, 3'd1, 10'd64,   1'b0, 510,   128},   // R4 8-bit
    '{2'd1, 3'd1, 10'd64,   1'b1, 510,   382},   // R6
    '{2'd2, 3'd1, 10'd300,  1'b0, 1022,  600},   // R2 9-bit
    '{2'd3, 3'd1, 10'd1000, 1'b0, 2046,  2000},  // R2 10-bit
    '{2'd1, 3'd2, 10'd10,   1'b0, 4080,  160},   // R8 div 8
    '{2'd1, 3'd1, 10'd0,    1'b0, 510,   0},     // R5 zero
    '{2'd1, 3'd1, 10'd255,  1'b0, 510,   510},   // R5 at peak
    '{2'd1, 3'd1, 10'd400,  1'b0, 510,   510},   // R5 above peak
    '{2'd1, 3'd1, 10'd0,    1'b1, 510,   510},   // R6 inverted zero
    '{2'd2, 3'd1, 10'd255,  1'b0, 1022,  510},   // R4 9-bit
    '{2'd0, 3'd1, 10'd100,  1'b0, 510,   200},   // R2 code 00
    '{2'd3, 3'd1, 10'd512,  1'b1, 2046,  1022}   // R6 10-bit
  };

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [9:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [9:0] cfg(input logic [1:0] r, input logic [2:0] p, input logic i);
    return {4'b0, i, p, r};
  endfunction

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic to_edge(input logic want, input int maxc, output int n);
    logic prev;
    prev = pwm_out;
    n = 0;
    while (n < maxc) begin
      @(negedge clk);
      n++;
      if (prev != want && pwm_out == want) break;
      prev = pwm_out;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int h, n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 output in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    count_high(50, h);
    chk("R1/R9 idle after reset", h, 0);

    foreach (VEC[i]) begin
      wr(1'b1, cfg(VEC[i].res, VEC[i].pre, VEC[i].inv));
      wr(1'b0, VEC[i].cmp);
      repeat (2 * VEC[i].win + 2048 * ((VEC[i].pre == 3'd2) ? 8 : 1)) @(negedge clk);
      count_high(VEC[i].win, h);
      chk($sformatf("R4 vector %0d high count", i), h, VEC[i].high);
    end

    // R3 period at 8 bits, divide by 1
    wr(1'b1, cfg(2'd1, 3'd1, 1'b0));
    wr(1'b0, 10'd64);
    repeat (1200) @(negedge clk);
    to_edge(1'b1, 2000, n);
    to_edge(1'b1, 2000, n);
    chk("R3 rise-to-rise period", n, 510);

    // R7 a write mid-pulse must not shorten it
    wr(1'b0, 10'd100);
    repeat (1200) @(negedge clk);
    to_edge(1'b1, 2000, n);
    wr(1'b0, 10'd20);
    to_edge(1'b0, 2000, n);
    chk("R7 pulse after mid-pulse write", n + 1, 200);
    to_edge(1'b1, 2000, n);
    to_edge(1'b0, 2000, n);
    chk("R7 next pulse uses new value", n, 40);

    // R10 shrink resolution while count is above new peak
    wr(1'b1, cfg(2'd3, 3'd1, 1'b0));
    wr(1'b0, 10'd200);
    repeat (6200) @(negedge clk);
    to_edge(1'b0, 3000, n);
    repeat (400) @(negedge clk);
    wr(1'b1, cfg(2'd1, 3'd1, 1'b0));
    to_edge(1'b1, 3000, n);
    chk("R10 turn down from new peak", n, 56);

    // R9 stop while high, then while low
    wr(1'b0, 10'd128);
    repeat (1200) @(negedge clk);
    to_edge(1'b1, 2000, n);
    wr(1'b1, cfg(2'd1, 3'd0, 1'b0));
    count_high(300, h);
    chk("R9 frozen high", h, 300);
    wr(1'b1, cfg(2'd1, 3'd1, 1'b0));
    to_edge(1'b0, 2000, n);
    wr(1'b1, cfg(2'd1, 3'd7, 1'b0));
    count_high(300, h);
    chk("R9 frozen low with code 7", h, 0);

    // R8 divide by 64 pulse width: 2*4*64
    wr(1'b1, cfg(2'd1, 3'd1, 1'b0));
    wr(1'b0, 10'd4);
    repeat (1200) @(negedge clk);
    wr(1'b1, cfg(2'd1, 3'd3, 1'b0));
    to_edge(1'b1, 40000, n);
    to_edge(1'b0, 40000, n);
    chk("R8 divide-by-64 pulse width", n, 512);

    // R1 reset mid-run clears output at once and restores defaults
    wr(1'b1, cfg(2'd1, 3'd1, 1'b0));
    wr(1'b0, 10'd255);
    repeat (1200) @(negedge clk);
    chk("R5 full-high before reset", int'(pwm_out), 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears output", int'(pwm_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    count_high(600, h);
    chk("R1 defaults after reset", h, 0);

    done = 1;
    report();
    $finish;
  end
endmodule